// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software manage an external Ethernet PHY over the two-wire MDIO bus through one 32-bit command register. A single write to that register holds a clause-22 transaction: the PHY address, the PHY register number, the direction and, for a write, the 16 data bits. The controller then generates the management clock and shifts out a complete 64-bit frame. For a read, it releases the data line and collects the reply from the PHY.

Software uses two status bits in the same register to pace itself. It polls a busy bit before issuing a command. After a read, it polls a valid bit; once that bit is set, the low 16 bits hold the value the PHY returned. A second small register holds the port's own 5-bit PHY address, which software may read or change at any time. The management clock runs only while a frame is in flight. Its period is the system clock period times a parameter, and the default parameter keeps a 250 MHz system clock at 2.5 MHz on the management clock.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command readback and PHY-address readback are all zeros, `mdc` is low and `mdio_oe` is low; `mdio_oe` is never high while busy is clear.
- R2: A command write (`reg_sel`=0) uses bits 15:0 as write data, 20:16 as PHY address, 25:21 as register number and bit 26 as direction (1 = read, 0 = write); the readback shows these fields at the same positions, with busy at bit 28, read-valid at bit 27 and bits 31:29 zero.
- R3: An accepted command sets busy in the clock after the accepting edge. Busy clears exactly 64*CLK_DIV clocks after that edge.
- R4: A command write that arrives while busy is set has no effect: the frame on the wire, the readback fields and the busy span all stay those of the command already in flight.
- R5: A write frame is 64 MDC bits, sent most significant bit first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits.
- R6: A read frame drives 32 ones, 01, opcode 10, PHY address and register number (46 bits, output enabled), then releases `mdio_oe` for the 18 remaining bits (turnaround and data).
- R7: During a read, `mdio_i` is sampled on each of the 16 rising MDC edges of the data phase, MSB first. When busy clears, bits 15:0 hold that value and read-valid (bit 27) is set. After a write, read-valid stays clear.
- R8: Read-valid clears in the cycle after an accepted command write.
- R9: While busy, MDC is high for CLK_DIV/2 clocks and low for CLK_DIV/2 clocks, with its first rise CLK_DIV/2 clocks after the accepting edge. MDC is low whenever busy is clear.
- R10: A write with `reg_sel`=1 stores bits 4:0 as the PHY-address register at any time, even while busy. Its readback has zeros above bit 4, and the stored value has no effect on the frame on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_sel | input | 1 | Register select: 0 command, 1 PHY address |
| reg_wdata | input | 27 | Write data (status bits 31:27 are not writable) |
| cmd_rdata | output | 32 | Command register readback with status bits |
| phyadr_rdata | output | 32 | PHY-address register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
Busy and read-valid are due in the clock after the accepting edge. The first MDC rise is due CLK_DIV/2 clocks after that edge and the first fall CLK_DIV clocks after it. Busy falls 64*CLK_DIV clocks after it, and read data is valid at that same point. The bench keeps a free-running posedge counter and stores its value at the first falling clock edge after the command is accepted. It samples every output on falling edges and compares elapsed counts with these exact figures, never with a range. A PHY model captures each MDC rise, rebuilds the frame and the output-enable pattern bit by bit, and answers reads with a value that the bench computes from the address pair.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_LEN  = 64;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int WDATA_W    = 27;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_START   = 46;
    localparam int DATA_START = 48;

    // Command register image; packed from bit 28 down to bit 0.
    typedef struct packed {
        logic              busy;
        logic              rvalid;
        logic              rd;
        logic [ADDR_W-1:0] reg_ad;
        logic [ADDR_W-1:0] phy_ad;
        logic [DATA_W-1:0] data;
    } cmd_reg_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] pa,
        input logic [ADDR_W-1:0] ra,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0]        op;
        logic [DATA_W-1:0] payload;
        op      = rd ? 2'b10 : 2'b01;
        payload = rd ? {DATA_W{1'b1}} : wd;
        return {{32{1'b1}}, 2'b01, op, pa, ra, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc      = st_q.mdc;
    assign rise_stb = run && (st_q.cnt == LAST) && !st_q.mdc;
    assign fall_stb = run && (st_q.cnt == LAST) &&  st_q.mdc;

    // R9: MDC only ever rises while the engine requests the clock
    assert_mdc_rise_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mdc) |-> $past(run));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 start_rd,
    input  logic [FRAME_LEN-1:0] start_frame,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 run,
    output logic                 done,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_W-1:0]    rd_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_START);
    localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_START);

    typedef struct packed {
        logic                 active;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] frame;
        logic [DATA_W-1:0]    shreg;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic       done_c;

    always_comb begin
        st_d   = st_q;
        done_c = 1'b0;
        if (start && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.rd     = start_rd;
            st_d.idx    = '0;
            st_d.frame  = start_frame;
            st_d.shreg  = '0;
        end else if (st_q.active) begin
            if (rise_stb && st_q.rd && (st_q.idx >= IDX_DAT)) begin
                st_d.shreg = {st_q.shreg[DATA_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (st_q.idx == IDX_LAST) begin
                    st_d.active = 1'b0;
                    done_c      = 1'b1;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.frame = {st_q.frame[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run     = st_q.active;
    assign done    = done_c;
    assign mdio_o  = st_q.frame[FRAME_LEN-1];
    assign mdio_oe = st_q.active && !(st_q.rd && (st_q.idx >= IDX_TA));
    assign rd_data = st_q.shreg;

    // R3: a new frame is only launched while the engine is idle
    assert_start_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !st_q.active);

    // R6: the pad is released whenever read data is sampled
    assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && st_q.active && st_q.rd && (st_q.idx >= IDX_DAT)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [31:0]        cmd_rdata,
    output logic [31:0]        phyadr_rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i
);
    localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;

    typedef struct packed {
        cmd_reg_t          cmd;
        logic [ADDR_W-1:0] paddr;
    } top_state_t;

    top_state_t           st_d, st_q;
    logic                 accept;
    logic                 eng_run;
    logic                 eng_done;
    logic                 rise_stb;
    logic                 fall_stb;
    logic [DATA_W-1:0]    eng_rdata;
    logic [FRAME_LEN-1:0] new_frame;

    assign accept    = reg_wr && !reg_sel && !st_q.cmd.busy;
    assign new_frame = build_frame(reg_wdata[26], reg_wdata[20:16],
                                   reg_wdata[25:21], reg_wdata[15:0]);

    always_comb begin
        st_d = st_q;
        if (eng_done) begin
            st_d.cmd.busy = 1'b0;
            if (st_q.cmd.rd) begin
                st_d.cmd.rvalid = 1'b1;
                st_d.cmd.data   = eng_rdata;
            end
        end
        if (accept) begin
            st_d.cmd.busy   = 1'b1;
            st_d.cmd.rvalid = 1'b0;
            st_d.cmd.rd     = reg_wdata[26];
            st_d.cmd.reg_ad = reg_wdata[25:21];
            st_d.cmd.phy_ad = reg_wdata[20:16];
            st_d.cmd.data   = reg_wdata[15:0];
        end
        if (reg_wr && reg_sel) begin
            st_d.paddr = reg_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_mdc_gen #(.HALF(HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_run),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_rd    (reg_wdata[26]),
        .start_frame (new_frame),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .mdio_i      (mdio_i),
        .run         (eng_run),
        .done        (eng_done),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .rd_data     (eng_rdata)
    );

    assign cmd_rdata    = {3'b000, st_q.cmd};
    assign phyadr_rdata = {{(32-ADDR_W){1'b0}}, st_q.paddr};

    // R1: the pad is only driven during a transaction
    assert_oe_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> st_q.cmd.busy);

    // R3: busy only rises after a command write
    assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.cmd.busy) |-> $past(reg_wr && !reg_sel));

    // R4: command fields hold while a frame is in flight
    assert_fields_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd.busy |=> $stable({st_q.cmd.rd, st_q.cmd.reg_ad, st_q.cmd.phy_ad}));

    // R7: read-valid never coexists with busy
    assert_valid_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd.rvalid |-> !st_q.cmd.busy);

    // R8: an accepted command clears read-valid
    assert_valid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !st_q.cmd.busy) |=> !st_q.cmd.rvalid);

    // R9: MDC rests low outside a transaction
    assert_mdc_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cmd.busy |-> !mdc);

endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
    localparam int DIV   = 8;
    localparam int HALFP = DIV / 2;
    localparam int SPAN  = 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [26:0] reg_wdata = '0;
    logic [31:0] cmd_rdata;
    logic [31:0] phyadr_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    longint cyc  = 0;

    mdio_mgmt_ctrl #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .phyadr_rdata(phyadr_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] phy_val(input logic [4:0] pa, input logic [4:0] ra);
        return {pa, ra, pa, 1'b1} ^ 16'hC35A;
    endfunction

    // PHY model: captures every MDC rise, answers reads
    logic        busy_bit;
    assign busy_bit = cmd_rdata[28];
    int          m_cnt = 0;
    int          m_len = 0;
    logic [63:0] m_cap = '0;
    logic [63:0] m_oe  = '0;
    logic [4:0]  m_pa  = '0;
    logic [4:0]  m_ra  = '0;

    always @(posedge mdc or negedge busy_bit) begin
        if (!busy_bit) begin
            m_len = m_cnt;
            m_cnt = 0;
        end else begin
            m_cap = {m_cap[62:0], mdio_o};
            m_oe  = {m_oe[62:0], mdio_oe};
            m_cnt = m_cnt + 1;
            if (m_cnt == 46) begin
                m_pa = m_cap[9:5];
                m_ra = m_cap[4:0];
            end
        end
    end

    always @(negedge mdc) begin
        logic [15:0] resp;
        resp = phy_val(m_pa, m_ra);
        if (m_cnt >= 48 && m_cnt <= 63) mdio_i = resp[63 - m_cnt];
        else                            mdio_i = 1'b1;
    end

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [26:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [26:0] cmd_word(input logic rd, input logic [4:0] pa,
                                             input logic [4:0] ra, input logic [15:0] d);
        return {rd, ra, pa, d};
    endfunction

    // issue a command; returns at the first falling edge after the accepting edge
    task automatic issue(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, output longint t0);
        write_reg(1'b0, cmd_word(rd, pa, ra, d));
        t0 = cyc;
        check(cmd_rdata[28] == 1'b1, "R3 busy after accept", 64'(cmd_rdata[28]), 64'd1);
        check(cmd_rdata[27] == 1'b0, "R8 valid cleared", 64'(cmd_rdata[27]), 64'd0);
    endtask

    task automatic finish(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] d, input longint t0);
        logic [63:0] exp_w;
        logic [45:0] exp_r;
        while (cmd_rdata[28]) @(negedge clk);
        check(cyc - t0 == SPAN, "R3 busy span", 64'(cyc - t0), 64'(SPAN));
        check(m_len == 64, "R9 MDC rises per frame", 64'(m_len), 64'd64);
        check(cmd_rdata[31:29] == 3'b000 && cmd_rdata[26:16] == {rd, ra, pa},
              "R2 readback fields", 64'(cmd_rdata[26:16]), 64'({rd, ra, pa}));
        if (rd) begin
            exp_r = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
            check(m_cap[63:18] == exp_r, "R6 read header", 64'(m_cap[63:18]), 64'(exp_r));
            check(m_oe == ~64'h3FFFF, "R6 read release", m_oe, ~64'h3FFFF);
            check(cmd_rdata[27] == 1'b1, "R7 valid set", 64'(cmd_rdata[27]), 64'd1);
            check(cmd_rdata[15:0] == phy_val(pa, ra), "R7 read data",
                  64'(cmd_rdata[15:0]), 64'(phy_val(pa, ra)));
        end else begin
            exp_w = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, d};
            check(m_cap == exp_w, "R5 write frame", m_cap, exp_w);
            check(m_oe == '1, "R5 write drive", m_oe, '1);
            check(cmd_rdata[27] == 1'b0, "R7 no valid on write", 64'(cmd_rdata[27]), 64'd0);
            check(cmd_rdata[15:0] == d, "R2 write data readback",
                  64'(cmd_rdata[15:0]), 64'(d));
        end
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle MDC low and R1 released",
              64'({mdc, mdio_oe}), 64'd0);
    endtask

    task automatic transact(input logic rd, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] d);
        longint t0;
        issue(rd, pa, ra, d, t0);
        finish(rd, pa, ra, d, t0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        longint t0;
        void'($urandom(32'h00C0FFEE));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(cmd_rdata == 32'h0 && phyadr_rdata == 32'h0, "R1 reset readback",
              {cmd_rdata, phyadr_rdata}, 64'd0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", 64'({mdc, mdio_oe}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 MDC phase timing on a directed write
        issue(1'b0, 5'd3, 5'd9, 16'h1234, t0);
        while (!mdc) @(negedge clk);
        check(cyc - t0 == HALFP, "R9 first rise", 64'(cyc - t0), 64'(HALFP));
        while (mdc) @(negedge clk);
        check(cyc - t0 == 2 * HALFP, "R9 first fall", 64'(cyc - t0), 64'(2 * HALFP));
        finish(1'b0, 5'd3, 5'd9, 16'h1234, t0);

        // boundary: all-ones write and all-zero read
        transact(1'b0, 5'd31, 5'd31, 16'hFFFF);
        transact(1'b1, 5'd0, 5'd0, 16'h0000);
        transact(1'b1, 5'd31, 5'd31, 16'h0000);
        // R8: a write after a read clears valid (checked in issue)
        transact(1'b0, 5'd0, 5'd0, 16'h0000);

        // R4: second command during a frame is dropped
        issue(1'b1, 5'd17, 5'd2, 16'h0000, t0);
        repeat (100) @(negedge clk);
        write_reg(1'b0, cmd_word(1'b0, 5'd5, 5'd6, 16'hBEEF));
        check(cmd_rdata[26:16] == {1'b1, 5'd2, 5'd17}, "R4 fields unchanged",
              64'(cmd_rdata[26:16]), 64'({1'b1, 5'd2, 5'd17}));
        // R10: address register writable while busy
        write_reg(1'b1, 27'h7FFFFE5);
        check(phyadr_rdata == 32'h5, "R10 addr readback", 64'(phyadr_rdata), 64'h5);
        finish(1'b1, 5'd17, 5'd2, 16'h0000, t0);
        check(phyadr_rdata == 32'h5, "R10 addr holds", 64'(phyadr_rdata), 64'h5);
        write_reg(1'b1, 27'h000001A);
        check(phyadr_rdata == 32'h1A, "R10 addr update", 64'(phyadr_rdata), 64'h1A);
        // R10: frame uses command address, not the stored one
        transact(1'b0, 5'd4, 5'd1, 16'h00A5);

        // random mix
        for (int i = 0; i < 20; i++) begin
            logic        rd;
            logic [4:0]  pa, ra;
            logic [15:0] d;
            rd = 1'($urandom);
            pa = 5'($urandom);
            ra = 5'($urandom);
            d  = 16'($urandom);
            transact(rd, pa, ra, d);
            repeat (1 + ($urandom % 7)) @(negedge clk);
        end
        summary();
    end
endmodule